// File: doc/BRIEF.md
# Short-Strobe Pulse Stretcher

This block converts an active-low strobe that may be only a few nanoseconds wide, far narrower than any clock period, into a long output pulse lasting on the order of a hundred milliseconds. Nothing in the block samples the strobe. The strobe acts as an asynchronous clear on a short chain of flip-flops. The first stage of the chain loads a constant one, and each later stage loads the stage before it. The chain advances only when a slow enable tick is present.

The tick lasts one system-clock cycle. A counter produces it by dividing the system clock by a parameter. With a 100 MHz clock, the default ratio gives a 10 Hz tick. While any stage of the chain is clear, the output is active. It therefore stays active from the moment the strobe arrives until the chain has refilled, which takes between one and two tick periods with the default two stages.

A system reset loads the chain full. As a result, no pulse appears until the first strobe. The polarity of the output is a parameter, and it defaults to active low to match the strobe.

Top module: `strobe_stretcher`

## Requirements
- R1: While rst_ni is low, and afterwards until the first strobe, pulse_o is at its inactive level and the chain is full (all stages 1). No pulse appears without a strobe.
- R2: A low level on strobe_ni clears every chain stage without waiting for a clock edge. pulse_o becomes active before the next rising edge of clk_i.
- R3: The tick is high for exactly one cycle, and it fires at every TICK_DIV-th rising edge of clk_i after rst_ni is released, counting the first edge after release as edge 1.
- R4: The chain changes only at tick edges. At a tick, the first stage loads 1 and every other stage loads the value of its predecessor. A single tick after a strobe does not end the pulse.
- R5: pulse_o is active while any stage is clear. For a strobe released between edge f and edge f+1, the pulse ends at edge (f/TICK_DIV + STAGES) * TICK_DIV, using integer division. With two stages, the width ranges from TICK_DIV+1 to 2*TICK_DIV clock cycles.
- R6: A strobe that arrives while the pulse is active clears the chain again. The pulse continues without a gap, and its end is recomputed from the new strobe.
- R7: While strobe_ni is held low across tick edges, the chain stays clear. The end of the pulse is computed from the release of the strobe.
- R8: With OUT_ACTIVE_LOW = 1, the active level of pulse_o is 0. With OUT_ACTIVE_LOW = 0, the active level is 1 and the output is otherwise identical.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that drives the tick divider and the chain |
| rst_ni | input | 1 | Asynchronous active-low system reset; fills the chain and clears the divider |
| strobe_ni | input | 1 | Active-low strobe of any width; asynchronously clears the chain |
| pulse_o | output | 1 | Stretched pulse, with its polarity set by OUT_ACTIVE_LOW |

## Verification
The hardest situations to reach from the ports are those where the strobe's phase relative to the hidden tick matters. These are a strobe just after a tick edge, which gives the longest pulse, a strobe just before one, which gives the shortest, and a second strobe landing inside a pulse that is already running. The bench keeps its own count of clock edges since reset release, which lets it work out the tick phase. It waits for a chosen phase and then fires a one-nanosecond strobe between edges. A scoreboard holds the predicted end edge of each pulse. A retrigger or a held strobe rewrites the pending end edge instead of adding a second pulse.

// File: rtl/stretch_pkg.sv
package stretch_pkg;

   // Counter width needed to hold values 0 .. div-1 (minimum one bit).
   function automatic int unsigned div_width(input int unsigned div);
      return (div <= 2) ? 1 : $clog2(div);
   endfunction

endpackage

// File: rtl/stretch_tick_gen.sv
module stretch_tick_gen #(
   parameter int unsigned DIV = 10_000_000,
   parameter int unsigned CW  = stretch_pkg::div_width(DIV)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   output logic          tick_o,
   output logic [CW-1:0] cnt_o
);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("stretch_tick_gen: DIV must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (cnt_q == LAST)   cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = (cnt_q == LAST);
   assign cnt_o  = cnt_q;
endmodule

// File: rtl/stretch_hold_chain.sv
module stretch_hold_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              strobe_ni,
   input  logic              tick_i,
   output logic [STAGES-1:0] chain_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("stretch_hold_chain: STAGES must be at least 2");
   end

   logic [STAGES-1:0] q;

   // Reset fills the chain; the strobe empties it; ticks shift ones in.
   always_ff @(posedge clk_i or negedge rst_ni or negedge strobe_ni) begin
      if (!rst_ni)         q <= '1;
      else if (!strobe_ni) q <= '0;
      else if (tick_i)     q <= {q[STAGES-2:0], 1'b1};
   end

   assign chain_o = q;
endmodule

// File: rtl/stretch_out_drive.sv
module stretch_out_drive #(
   parameter int unsigned STAGES         = 2,
   parameter bit          OUT_ACTIVE_LOW = 1'b1
) (
   input  logic [STAGES-1:0] chain_i,
   output logic              pulse_o
);
   logic busy;

   // Active while any stage has not yet refilled.
   assign busy = ~(&chain_i);

   if (OUT_ACTIVE_LOW) begin : g_low
      assign pulse_o = ~busy;
   end else begin : g_high
      assign pulse_o = busy;
   end
endmodule

// File: rtl/strobe_stretcher.sv
module strobe_stretcher #(
   parameter int unsigned TICK_DIV       = 10_000_000,
   parameter int unsigned STAGES         = 2,
   parameter bit          OUT_ACTIVE_LOW = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic strobe_ni,
   output logic pulse_o
);
   localparam int unsigned CW = stretch_pkg::div_width(TICK_DIV);

   logic              tick;
   logic [CW-1:0]     tick_cnt;
   logic [STAGES-1:0] chain;

   stretch_tick_gen #(.DIV(TICK_DIV), .CW(CW)) tick_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick),
      .cnt_o  (tick_cnt)
   );

   stretch_hold_chain #(.STAGES(STAGES)) chain_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .strobe_ni (strobe_ni),
      .tick_i    (tick),
      .chain_o   (chain)
   );

   stretch_out_drive #(.STAGES(STAGES), .OUT_ACTIVE_LOW(OUT_ACTIVE_LOW)) drive_i (
      .chain_i (chain),
      .pulse_o (pulse_o)
   );
endmodule

// File: rtl/strobe_stretcher_chk.sv
module strobe_stretcher_chk #(
   parameter int unsigned DIV    = 10,
   parameter int unsigned STAGES = 2,
   parameter int unsigned CW     = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              tick_i,
   input logic [CW-1:0]     cnt_i,
   input logic [STAGES-1:0] chain_i
);
   assert_tick_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i |=> !tick_i);

   assert_cnt_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_i <= CW'(DIV - 1));

   assert_rise_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(chain_i[STAGES-1]) |-> $past(tick_i));

   assert_rise_after_prev_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(chain_i[STAGES-1]) |-> $past(chain_i[STAGES-2]));

   for (genvar j = 0; j < STAGES - 1; j++) begin : g_order
      assert_fill_order_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
         chain_i[j+1] |-> chain_i[j]);
   end
endmodule

bind strobe_stretcher strobe_stretcher_chk #(.DIV(TICK_DIV), .STAGES(STAGES), .CW(CW)) chk_i (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .tick_i  (tick),
   .cnt_i   (tick_cnt),
   .chain_i (chain)
);

// File: tb/strobe_stretcher_tb_top.sv
`timescale 1ns/1ps
module strobe_stretcher_tb_top;
   localparam int DIV = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic strobe_n = 1'b1;
   logic pulse_lo, pulse_hi;

   int checks = 0;
   int errors = 0;
   int ec = 0;                    // rising edges since reset release
   int exp_start[$];
   int exp_end[$];
   string exp_tag[$];
   int run_len = 0;
   int hi_len = 0;

   always #5 clk = ~clk;

   strobe_stretcher #(.TICK_DIV(DIV), .OUT_ACTIVE_LOW(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .strobe_ni(strobe_n), .pulse_o(pulse_lo));

   strobe_stretcher #(.TICK_DIV(DIV), .OUT_ACTIVE_LOW(1'b0)) dut_hi_i (
      .clk_i(clk), .rst_ni(rst_n), .strobe_ni(strobe_n), .pulse_o(pulse_hi));

   always @(posedge clk) if (rst_n) ec <= ec + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Returns right after the rising edge whose count modulo DIV is p.
   task automatic wait_phase(input int p);
      do begin
         @(posedge clk); #1;
      end while (ec % DIV != p);
   endtask

   // Fire a strobe 3 ns after an edge; hold > 0 keeps it low over that many edges.
   task automatic fire(input int hold, input string tag);
      int e, f, t_end;
      #2;
      e = ec;
      strobe_n = 1'b0;
      #1;
      chk(pulse_lo == 1'b0, "R2", "pulse active before next edge", pulse_lo, 0);
      if (hold == 0) begin
         strobe_n = 1'b1;
         f = e;
      end else begin
         repeat (hold) @(posedge clk);
         #3;
         f = ec;
         strobe_n = 1'b1;
      end
      t_end = (f / DIV + 2) * DIV;
      if (exp_end.size() > 0) begin
         exp_end[exp_end.size()-1] = t_end;
         exp_tag[exp_tag.size()-1] = tag;
      end else begin
         exp_start.push_back(e);
         exp_end.push_back(t_end);
         exp_tag.push_back(tag);
      end
   endtask

   // Monitor: measure each pulse of the active-low instance at falling edges.
   always @(negedge clk) begin
      if (rst_n) begin
         if (pulse_lo == 1'b0) begin
            run_len++;
            if (pulse_hi) hi_len++;
         end else if (run_len > 0) begin
            if (exp_end.size() == 0) begin
               chk(1'b0, "R1", "unexpected pulse width", run_len, 0);
            end else begin
               int s, t;
               string tg;
               s = exp_start.pop_front();
               t = exp_end.pop_front();
               tg = exp_tag.pop_front();
               chk(run_len == t - s, tg, "pulse width", run_len, t - s);
               chk(hi_len == run_len, "R8", "active-high copy width", hi_len, run_len);
            end
            run_len = 0;
            hi_len = 0;
         end
      end
   end

   initial begin
      #(200000 * 10);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk(pulse_lo == 1'b1, "R1", "low-active output idle in reset", pulse_lo, 1);
      chk(pulse_hi == 1'b0, "R8", "high-active output idle in reset", pulse_hi, 0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (3 * DIV) @(posedge clk);
      #2;
      chk(pulse_lo == 1'b1, "R1", "no pulse without strobe", pulse_lo, 1);

      // Strobe right after a tick edge: longest pulse (R3, R5).
      wait_phase(0);
      fire(0, "R3");
      repeat (3 * DIV) @(posedge clk);

      // Strobe one edge before a tick: shortest pulse.
      wait_phase(DIV - 1);
      fire(0, "R5");
      repeat (3 * DIV) @(posedge clk);

      // Mid-period strobe; also check the pulse survives the first tick (R4).
      wait_phase(3);
      fire(0, "R5");
      wait_phase(1);
      #1;
      chk(pulse_lo == 1'b0, "R4", "pulse still active after one tick", pulse_lo, 0);
      repeat (3 * DIV) @(posedge clk);

      // Retrigger inside an active pulse.
      wait_phase(2);
      fire(0, "R6");
      repeat (5) @(posedge clk);
      #1;
      fire(0, "R6");
      repeat (3 * DIV) @(posedge clk);

      // Strobe held low across tick edges.
      wait_phase(1);
      fire(12, "R7");
      repeat (3 * DIV) @(posedge clk);

      // Idle again, no pending expectation.
      #2;
      chk(pulse_lo == 1'b1, "R1", "idle after pulses", pulse_lo, 1);
      chk(pulse_hi == 1'b0, "R8", "high-active idle after pulses", pulse_hi, 0);
      chk(exp_end.size() == 0, "R5", "all expected pulses seen", exp_end.size(), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule